// File: doc/BRIEF.md
# Slave Register Access Interface

This block is the slave side of a host bus built on one shared address/data path with active-low chip select, read strobe, write strobe and address strobe. It turns host bus cycles into single-cycle read and write requests toward an internal register file. The address and the transfer size are taken from the shared path when the address strobe rises. Write data is taken when the write strobe rises. Read data is driven while the read strobe stays low. It also answers interrupt acknowledge cycles with a vector that the interrupt logic supplies.

All bus inputs are resynchronized into the block clock. One handshake output, always driven, can work in two ways. In wait mode it holds the host off during an interrupt acknowledge until the vector is ready, and it stays quiet for register accesses. In acknowledge mode it confirms register reads, register writes and a ready interrupt acknowledge. The mode comes from the level of a select pin at the first write to the configuration register. Until a reset it cannot be changed again.

Top module: `slave_regif`

## Requirements
- R1: After reset, hs_n is 1, ad_oe is 0, reg_wr and reg_rd are 0, and the handshake works in wait mode.
- R2: When as_n rises, reg_addr takes ad_in[ADDR_W-1:0] and reg_byte takes ad_in[BYTE_BIT] (1 means an 8-bit transfer). Both hold until the next rising edge of as_n, whatever ad_in does in between.
- R3: A rise of wr_n that ends a write strobe with cs_n low gives exactly one single-cycle reg_wr pulse. On that pulse reg_wdata holds ad_in as it was at the edge, with bits 15:8 forced to 0 for an 8-bit transfer. A write strobe with cs_n high gives no pulse.
- R4: A read strobe with cs_n low gives exactly one single-cycle reg_rd pulse for the latched reg_addr. Soon after, ad_oe goes to 1 and ad_out carries reg_rdata, with bits 15:8 forced to 0 for an 8-bit transfer. ad_oe returns to 0 after rd_n goes back high.
- R5: A read strobe with both cs_n and intack_n high is ignored: no reg_rd pulse, and ad_oe stays 0.
- R6: The first write to address CFG_ADDR (default 0) sets the mode from hs_sel as it was at that write: 1 gives wait mode, 0 gives acknowledge mode. Later writes to CFG_ADDR leave the mode unchanged until reset.
- R7: In wait mode, hs_n never goes low for register reads or writes. During an interrupt acknowledge (intack_n and rd_n low, cs_n high), hs_n is low until iack_ready is 1. After that hs_n goes high, ad_oe is 1 and ad_out equals iack_vec.
- R8: In acknowledge mode, hs_n goes low during a qualified write strobe and during a register read once read data is driven. During an interrupt acknowledge, hs_n stays high until iack_ready is 1, then goes low while iack_vec is driven. Otherwise hs_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| as_n | input | 1 | Address strobe, active low; address and size latched on its rising edge |
| intack_n | input | 1 | Interrupt acknowledge, active low |
| hs_sel | input | 1 | Handshake mode select, sampled at the first configuration write |
| ad_in | input | 16 | Shared address/data path, input side |
| ad_out | output | 16 | Read data or vector driven toward the host |
| ad_oe | output | 1 | Output enable for ad_out |
| hs_n | output | 1 | Wait/acknowledge handshake, always driven |
| reg_addr | output | ADDR_W | Latched register address |
| reg_byte | output | 1 | Latched size, 1 for an 8-bit transfer |
| reg_wr | output | 1 | Single-cycle register write request |
| reg_wdata | output | 16 | Write data sent with reg_wr |
| reg_rd | output | 1 | Single-cycle register read request |
| reg_rdata | input | 16 | Register file read data for reg_addr |
| iack_ready | input | 1 | Interrupt logic is ready to finish an acknowledge |
| iack_vec | input | 16 | Vector returned in an interrupt acknowledge |

## Verification
The assertions check the following on every cycle:
- request pulses last a single cycle;
- a read request only follows a chip-selected read strobe;
- the latched address changes only on an address strobe edge;
- the mode cannot move once it is locked;
- a low handshake always has a legal cause for the current mode.

Only the bench scenarios can show the rest: that the right data and vector values reach the ports, that unselected strobes really do nothing, and that the select pin level at the first configuration write decides the handshake behaviour of later accesses in both modes.

// File: rtl/slave_regif_pkg.sv
package slave_regif_pkg;
  localparam int DATA_W = 16;
  localparam int LANE_W = 8;
  localparam int CTL_W  = 5;

  typedef struct packed {
    logic cs_n;
    logic rd_n;
    logic wr_n;
    logic as_n;
    logic intack_n;
  } bus_ctl_t;

  // Zero the upper lane for an 8-bit transfer.
  function automatic logic [DATA_W-1:0] size_fit(input logic [DATA_W-1:0] d,
                                                 input logic is_byte);
    logic [DATA_W-1:0] r;
    r = d;
    if (is_byte) r[DATA_W-1:LANE_W] = '0;
    return r;
  endfunction

  // Handshake level request: 1 means drive the line low.
  function automatic logic hs_want(input logic mode_wait, input logic iack_act,
                                   input logic rd_reg_act, input logic wr_act,
                                   input logic valid);
    logic w;
    if (mode_wait) w = iack_act & ~valid;
    else           w = wr_act | ((rd_reg_act | iack_act) & valid);
    return w;
  endfunction
endpackage

// File: rtl/slave_regif_sync.sv
module slave_regif_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= INIT;
          else     stage_q[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= INIT;
          else     stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/slave_regif_decode.sv
module slave_regif_decode
  import slave_regif_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  bus_ctl_t ctl,
  output logic     wr_act,
  output logic     rd_reg_act,
  output logic     iack_act,
  output logic     rd_act,
  output logic     as_rise,
  output logic     wr_done,
  output logic     rd_start_reg,
  output logic     rd_start_iack
);
  logic cs_low;
  logic as_prev_q, wr_prev_q, rdr_prev_q, iack_prev_q;

  assign cs_low     = ~ctl.cs_n;
  assign wr_act     = ~ctl.wr_n & cs_low;
  assign rd_reg_act = ~ctl.rd_n & cs_low;
  assign iack_act   = ~ctl.rd_n & ~ctl.intack_n & ~cs_low;
  assign rd_act     = rd_reg_act | iack_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      as_prev_q   <= 1'b1;
      wr_prev_q   <= 1'b0;
      rdr_prev_q  <= 1'b0;
      iack_prev_q <= 1'b0;
    end else begin
      as_prev_q   <= ctl.as_n;
      wr_prev_q   <= wr_act;
      rdr_prev_q  <= rd_reg_act;
      iack_prev_q <= iack_act;
    end
  end

  assign as_rise       = ctl.as_n & ~as_prev_q;
  assign wr_done       = ctl.wr_n & wr_prev_q;
  assign rd_start_reg  = rd_reg_act & ~rdr_prev_q;
  assign rd_start_iack = iack_act & ~iack_prev_q;
endmodule

// File: rtl/slave_regif_xfer.sv
module slave_regif_xfer
  import slave_regif_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int BYTE_BIT = 15,
  parameter int CFG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] ad_s,
  input  logic              as_rise,
  input  logic              wr_done,
  input  logic              rd_start_reg,
  input  logic              rd_start_iack,
  input  logic              rd_act,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic              iack_ready,
  input  logic [DATA_W-1:0] iack_vec,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_byte,
  output logic              reg_wr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_rd,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              data_valid,
  output logic              cfg_write
);
  logic [ADDR_W-1:0] addr_q;
  logic              byte_q;
  logic [DATA_W-1:0] hold_q;
  logic              valid_q, pend_q;
  logic              vec_load;

  assign cfg_write = wr_done && (addr_q == ADDR_W'(CFG_ADDR));
  assign vec_load  = pend_q & iack_ready & rd_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      byte_q <= 1'b0;
    end else if (as_rise) begin
      addr_q <= ad_s[ADDR_W-1:0];
      byte_q <= ad_s[BYTE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_wr    <= 1'b0;
      reg_wdata <= '0;
      reg_rd    <= 1'b0;
    end else begin
      reg_wr <= wr_done;
      reg_rd <= rd_start_reg;
      if (wr_done) reg_wdata <= size_fit(ad_s, byte_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (rd_start_iack) pend_q <= 1'b1;
      if (reg_rd) begin
        hold_q  <= size_fit(reg_rdata, byte_q);
        valid_q <= 1'b1;
      end
      if (vec_load) begin
        hold_q  <= iack_vec;
        valid_q <= 1'b1;
        pend_q  <= 1'b0;
      end
      if (!rd_act) begin
        valid_q <= 1'b0;
        pend_q  <= 1'b0;
      end
    end
  end

  assign reg_addr   = addr_q;
  assign reg_byte   = byte_q;
  assign ad_out     = hold_q;
  assign data_valid = valid_q;
  assign ad_oe      = valid_q & rd_act;
endmodule

// File: rtl/slave_regif_handshake.sv
module slave_regif_handshake
  import slave_regif_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cfg_write,
  input  logic sel_s,
  input  logic wr_act,
  input  logic rd_reg_act,
  input  logic iack_act,
  input  logic data_valid,
  output logic mode_wait,
  output logic mode_set,
  output logic hs_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_wait <= 1'b1;
      mode_set  <= 1'b0;
    end else if (cfg_write && !mode_set) begin
      mode_wait <= sel_s;
      mode_set  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hs_n <= 1'b1;
    else     hs_n <= ~hs_want(mode_wait, iack_act, rd_reg_act, wr_act, data_valid);
  end
endmodule

// File: rtl/slave_regif.sv
module slave_regif
  import slave_regif_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int BYTE_BIT = 15,
  parameter int CFG_ADDR = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              as_n,
  input  logic              intack_n,
  input  logic              hs_sel,
  input  logic [15:0]       ad_in,
  output logic [15:0]       ad_out,
  output logic              ad_oe,
  output logic              hs_n,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_byte,
  output logic              reg_wr,
  output logic [15:0]       reg_wdata,
  output logic              reg_rd,
  input  logic [15:0]       reg_rdata,
  input  logic              iack_ready,
  input  logic [15:0]       iack_vec
);
  localparam logic [CTL_W-1:0] CTL_IDLE = '1;

  bus_ctl_t          ctl_raw, ctl_s;
  logic [CTL_W-1:0]  ctl_q;
  logic [DATA_W:0]   dat_q;
  logic [DATA_W-1:0] ad_s;
  logic              sel_s;

  logic wr_act_w, rd_reg_act_w, iack_act_w, rd_act_w;
  logic as_rise_w, wr_done_w, rd_start_reg_w, rd_start_iack_w;
  logic data_valid_w, cfg_write_w, mode_wait_w, mode_set_w;

  assign ctl_raw = '{cs_n: cs_n, rd_n: rd_n, wr_n: wr_n, as_n: as_n, intack_n: intack_n};

  slave_regif_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .INIT(CTL_IDLE)) u_ctl_sync (
    .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_q));

  slave_regif_sync #(.W(DATA_W+1), .STAGES(SYNC_STAGES), .INIT('0)) u_dat_sync (
    .clk(clk), .rst(rst), .d({hs_sel, ad_in}), .q(dat_q));

  assign ctl_s = bus_ctl_t'(ctl_q);
  assign ad_s  = dat_q[DATA_W-1:0];
  assign sel_s = dat_q[DATA_W];

  slave_regif_decode u_dec (
    .clk(clk), .rst(rst), .ctl(ctl_s),
    .wr_act(wr_act_w), .rd_reg_act(rd_reg_act_w), .iack_act(iack_act_w),
    .rd_act(rd_act_w), .as_rise(as_rise_w), .wr_done(wr_done_w),
    .rd_start_reg(rd_start_reg_w), .rd_start_iack(rd_start_iack_w));

  slave_regif_xfer #(.ADDR_W(ADDR_W), .BYTE_BIT(BYTE_BIT), .CFG_ADDR(CFG_ADDR)) u_xfer (
    .clk(clk), .rst(rst), .ad_s(ad_s), .as_rise(as_rise_w), .wr_done(wr_done_w),
    .rd_start_reg(rd_start_reg_w), .rd_start_iack(rd_start_iack_w), .rd_act(rd_act_w),
    .reg_rdata(reg_rdata), .iack_ready(iack_ready), .iack_vec(iack_vec),
    .reg_addr(reg_addr), .reg_byte(reg_byte), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .ad_out(ad_out), .ad_oe(ad_oe), .data_valid(data_valid_w),
    .cfg_write(cfg_write_w));

  slave_regif_handshake u_hs (
    .clk(clk), .rst(rst), .cfg_write(cfg_write_w), .sel_s(sel_s),
    .wr_act(wr_act_w), .rd_reg_act(rd_reg_act_w), .iack_act(iack_act_w),
    .data_valid(data_valid_w), .mode_wait(mode_wait_w), .mode_set(mode_set_w),
    .hs_n(hs_n));
endmodule

// File: rtl/slave_regif_chk.sv
module slave_regif_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              hs_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              as_rise_w,
  input logic              mode_set_w,
  input logic              mode_wait_w,
  input logic              wr_act_w,
  input logic              rd_act_w,
  input logic              rd_reg_act_w,
  input logic              iack_act_w
);
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst) reg_wr |=> !reg_wr); // R3
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst) reg_rd |=> !reg_rd); // R4
  AST_RD_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    reg_rd |-> $past(rd_reg_act_w)); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !as_rise_w |=> $stable(reg_addr)); // R2
  AST_MODE_LOCK: assert property (@(posedge clk) disable iff (rst)
    mode_set_w |=> (mode_set_w && $stable(mode_wait_w))); // R6
  AST_WAIT_IACK_ONLY: assert property (@(posedge clk) disable iff (rst)
    (!hs_n && $past(mode_wait_w)) |-> $past(iack_act_w)); // R7
  AST_ACK_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (!hs_n && !$past(mode_wait_w)) |-> $past(rd_act_w || wr_act_w)); // R8
endmodule

bind slave_regif slave_regif_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .hs_n(hs_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .as_rise_w(as_rise_w), .mode_set_w(mode_set_w),
  .mode_wait_w(mode_wait_w), .wr_act_w(wr_act_w), .rd_act_w(rd_act_w),
  .rd_reg_act_w(rd_reg_act_w), .iack_act_w(iack_act_w));

// File: tb/slave_regif_test.sv
`timescale 1ns/1ps
module slave_regif_test;
  localparam int AW = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, as_n = 1'b1, intack_n = 1'b1;
  logic hs_sel = 1'b0, iack_ready = 1'b0;
  logic [15:0] ad_in = '0, iack_vec = '0, reg_rdata;
  logic [15:0] ad_out, reg_wdata;
  logic ad_oe, hs_n, reg_byte, reg_wr, reg_rd;
  logic [AW-1:0] reg_addr;

  int checks = 0, errors = 0;
  int wr_cnt = 0, rd_cnt = 0, hs_low = 0;
  logic [15:0] last_wdata = '0;
  bit exp_wait = 1'b1, locked = 1'b0, done = 1'b0;

  always #2 clk = ~clk;

  slave_regif uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .as_n(as_n),
    .intack_n(intack_n), .hs_sel(hs_sel), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .hs_n(hs_n), .reg_addr(reg_addr), .reg_byte(reg_byte), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .iack_ready(iack_ready), .iack_vec(iack_vec));

  function automatic logic [15:0] model(input logic [AW-1:0] a);
    return (16'(a) * 16'h0259) ^ 16'hA5C3;
  endfunction

  function automatic logic [15:0] fit(input logic [15:0] d, input bit b);
    return b ? {8'h00, d[7:0]} : d;
  endfunction

  assign reg_rdata = model(reg_addr);

  always @(negedge clk) begin
    if (reg_wr) begin wr_cnt++; last_wdata = reg_wdata; end
    if (reg_rd) rd_cnt++;
    if (!hs_n) hs_low++;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic addr_phase(input logic [AW-1:0] a, input bit b);
    ad_in = '0; ad_in[AW-1:0] = a; ad_in[15] = b;
    as_n = 1'b0; cyc(4); as_n = 1'b1; cyc(6);
    check(reg_addr == a && reg_byte == b, "R2 address/size latch", {reg_byte, reg_addr}, {b, a});
  endtask

  task automatic do_write(input logic [AW-1:0] a, input bit b, input logic [15:0] d,
                          input bit sel, input bit sel_cs);
    int w0;
    bit hs_exp;
    addr_phase(a, b);
    w0 = wr_cnt; hs_exp = !exp_wait && sel_cs;
    cs_n = !sel_cs; ad_in = d; hs_sel = sel; hs_low = 0;
    wr_n = 1'b0; cyc(6); wr_n = 1'b1; cyc(6); cs_n = 1'b1; cyc(4);
    check(reg_addr == a, "R2 address held through data phase", reg_addr, a);
    check(wr_cnt == w0 + (sel_cs ? 1 : 0), "R3 write pulse count", wr_cnt - w0, sel_cs);
    if (sel_cs) check(last_wdata == fit(d, b), "R3 write data", last_wdata, fit(d, b));
    if (hs_exp) check(hs_low > 0, "R8 ack on write", hs_low, 1);
    else check(hs_low == 0, "R7 no handshake on write", hs_low, 0);
    if (sel_cs && a == 0 && !locked) begin locked = 1'b1; exp_wait = sel; end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input bit b, input bit sel_cs);
    int r0;
    logic [15:0] e;
    addr_phase(a, b);
    r0 = rd_cnt; e = fit(model(a), b);
    cs_n = !sel_cs; ad_in = 16'hFFFF; hs_low = 0;
    rd_n = 1'b0; cyc(10);
    if (sel_cs) begin
      check(ad_oe == 1'b1 && ad_out == e, "R4 read data driven", {ad_oe, ad_out}, {1'b1, e});
      check(hs_n == exp_wait, "R7/R8 handshake during read", hs_n, exp_wait);
    end else begin
      check(ad_oe == 1'b0, "R5 ignored read keeps ad_oe low", ad_oe, 0);
    end
    rd_n = 1'b1; cyc(8); cs_n = 1'b1; cyc(2);
    check(ad_oe == 1'b0 && hs_n == 1'b1, "R4 release after read", {ad_oe, hs_n}, 2'b01);
    check(rd_cnt == r0 + (sel_cs ? 1 : 0), sel_cs ? "R4 read pulse count" : "R5 no read pulse",
          rd_cnt - r0, sel_cs);
    if (exp_wait) check(hs_low == 0, "R7 no handshake on read", hs_low, 0);
  endtask

  task automatic do_iack(input logic [15:0] v);
    int r0;
    r0 = rd_cnt; iack_vec = v; iack_ready = 1'b0;
    intack_n = 1'b0; rd_n = 1'b0; cyc(10);
    check(ad_oe == 1'b0, "R7/R8 no vector before ready", ad_oe, 0);
    check(hs_n == !exp_wait, exp_wait ? "R7 wait held" : "R8 no ack before ready", hs_n, !exp_wait);
    iack_ready = 1'b1; cyc(10);
    check(ad_oe == 1'b1 && ad_out == v, "R7/R8 vector driven", {ad_oe, ad_out}, {1'b1, v});
    check(hs_n == exp_wait, exp_wait ? "R7 wait released" : "R8 ack on vector", hs_n, exp_wait);
    rd_n = 1'b1; intack_n = 1'b1; iack_ready = 1'b0; cyc(8);
    check(ad_oe == 1'b0 && hs_n == 1'b1 && rd_cnt == r0, "R7 iack end", {ad_oe, hs_n}, 2'b01);
  endtask

  task automatic do_reset();
    rst = 1'b1; cyc(4); rst = 1'b0; cyc(2);
    exp_wait = 1'b1; locked = 1'b0;
    check(hs_n == 1'b1 && ad_oe == 1'b0 && reg_wr == 1'b0 && reg_rd == 1'b0,
          "R1 reset state", {hs_n, ad_oe, reg_wr, reg_rd}, 4'b1000);
  endtask

  task automatic random_mix(input int n);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] a;
      bit b;
      a = AW'($urandom_range(1, (1 << AW) - 1));
      b = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 1) == 1) do_write(a, b, 16'($urandom), $urandom_range(0, 1) == 1, 1'b1);
      else do_read(a, b, 1'b1);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // Default wait mode before any configuration write (R1, R7).
    do_write(7'h05, 1'b0, 16'hBEEF, 1'b0, 1'b1);
    do_read(7'h05, 1'b0, 1'b1);
    do_write(7'h11, 1'b1, 16'hC3A7, 1'b0, 1'b1);   // R3 byte write
    do_read(7'h12, 1'b1, 1'b1);                    // R4 byte read
    do_write(7'h20, 1'b0, 16'h1234, 1'b0, 1'b0);   // R3 unselected
    do_read(7'h21, 1'b0, 1'b0);                    // R5 unselected
    do_iack(16'h00C8);
    // R6: first config write with select high keeps wait mode, later write ignored.
    do_write(7'h00, 1'b0, 16'h0001, 1'b1, 1'b1);
    do_write(7'h00, 1'b0, 16'h0002, 1'b0, 1'b1);
    do_write(7'h33, 1'b0, 16'h5A5A, 1'b0, 1'b1);   // R6 still wait
    random_mix(12);
    do_iack(16'h7E01);

    do_reset();
    // R6: first config write with select low gives acknowledge mode.
    do_write(7'h00, 1'b0, 16'h0003, 1'b0, 1'b1);
    do_write(7'h44, 1'b0, 16'h0F0F, 1'b0, 1'b1);   // R8 ack
    do_write(7'h00, 1'b1, 16'h0004, 1'b1, 1'b1);   // R6 ignored
    do_write(7'h45, 1'b1, 16'hABCD, 1'b1, 1'b1);   // R6 still ack
    do_read(7'h46, 1'b0, 1'b1);
    do_read(7'h47, 1'b0, 1'b0);                    // R5 in ack mode
    do_write(7'h48, 1'b0, 16'h9999, 1'b0, 1'b0);   // R3 unselected in ack mode
    do_iack(16'h3301);
    random_mix(12);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule